// File: doc/BRIEF.md
# I2C SCL Period Generator

This block sets the timing of the SCL clock for an I2C master. It counts input-clock cycles to size the low and high halves of each SCL period. A second, shorter interval holds SCL high after a START condition. Two count pairs are held, one for standard mode and one for fast mode. A speed-select input picks which pair is used. All counts are written through a small configuration port, and that port accepts writes only while the generator is disabled.

The block drives SCL through an open-drain enable: when `scl_oe` is 1 the pad pulls the line low, and when it is 0 the line is released. The block also watches the real line through a sampling register. The low phase is counted from the first cycle the block pulls the line low. The high phase is counted only once the sampled line reads high, so a slow rise lengthens the high phase instead of cutting it short. A bit-level sequencer is expected to follow the one-cycle edge ticks and `hold_active` to place SDA changes.

When `enable` rises, the block leaves idle with a start-hold interval. It then alternates low and high phases until `enable` falls, and at that point it releases the line at once.

Top module: `i2c_scl_period_gen`

## Requirements
- R1: After reset `scl_oe`, `hold_active`, `fall_tick` and `rise_tick` are 0, and all four count registers hold 0, so the minimum lengths of R7 apply until they are written.
- R2: `speed_mode` = 2 selects the fast-mode pair. Every other value (1 in normal use, and also 0 and 3) selects the standard-mode pair. The value is captured when the generator leaves idle, and a change while `enable` stays 1 has no effect until the next enable.
- R3: A write with `cfg_wr` = 1 loads `cfg_wdata` into the register chosen by `cfg_addr`: 0 is standard high, 1 is standard low, 2 is fast high and 3 is fast low. Writes made while `enable` is 1 are dropped.
- R4: Each low phase keeps `scl_oe` at 1 for L+1 cycles, where L is the effective low count. The count starts in the first cycle `scl_oe` is 1.
- R5: Each high phase keeps `scl_oe` at 0 for H+8 cycles when the line rises as soon as it is released, where H is the effective high count. Counting waits for the sampled line to read high, so every extra cycle the line stays low after release adds one cycle to the phase.
- R6: When `enable` rises while the block is idle, `hold_active` is 1 for H+3 cycles with the line released. The first low phase follows directly, and `hold_active` and `scl_oe` are never 1 together.
- R7: A high count below 6 acts as 6, and a low count below 8 acts as 8.
- R8: `fall_tick` is 1 only in the first cycle of each low phase. `rise_tick` is 1 only in the first cycle of each high phase. Each occurs once per SCL period.
- R9: One cycle after `enable` is seen at 0, `scl_oe` and `hold_active` are 0 and the generator is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator when 1; returns it to idle when 0 |
| speed_mode | input | 2 | 2 = fast pair, other values = standard pair |
| cfg_wr | input | 1 | Count register write strobe |
| cfg_addr | input | 2 | Count register select (0 std high, 1 std low, 2 fast high, 3 fast low) |
| cfg_wdata | input | CNT_W (16) | Count value to write |
| scl_in | input | 1 | Observed level of the SCL line |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| hold_active | output | 1 | 1 during the start-hold interval |
| fall_tick | output | 1 | One-cycle pulse at the start of each low phase |
| rise_tick | output | 1 | One-cycle pulse at the start of each high phase |

## Verification
The bench measures every phase length at the pins while holding SCL low for extra cycles after release. A design that counted the high phase from the release, rather than from the sampled line, would return a high phase too short by the stretch. Counts below the minimums, the "other" speed values, and writes or speed changes while enabled are each checked by measuring a later phase. A missed clamp would show up as short phases. Leaking writes or speed changes would alter the next low phase. Dropping `enable` in the middle of the hold or a low phase checks that the line is released in the next cycle, and not left held low.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    // Generator phase
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    // Count register index as decoded from cfg_addr
    typedef enum logic [1:0] {
        SEL_STD_HI  = 2'd0,
        SEL_STD_LO  = 2'd1,
        SEL_FAST_HI = 2'd2,
        SEL_FAST_LO = 2'd3
    } cnt_sel_e;

    localparam int unsigned NUM_CNT_REGS  = 4;
    localparam logic [1:0]  SPEED_FAST    = 2'd2;

    // Minimum effective counts
    localparam int unsigned HI_MIN        = 6;
    localparam int unsigned LO_MIN        = 8;

    // Fixed overheads added to the programmed counts
    localparam int unsigned HI_OVERHEAD   = 8;
    localparam int unsigned LO_OVERHEAD   = 1;
    localparam int unsigned HOLD_OVERHEAD = 3;

endpackage

// File: rtl/sclgen_count_bank.sv
module sclgen_count_bank
    import sclgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             fast_sel,
    output logic [CNT_W-1:0] hi_eff,
    output logic [CNT_W-1:0] lo_eff
);

    logic [CNT_W-1:0] cnt_q [NUM_CNT_REGS];
    logic [CNT_W-1:0] hi_raw;
    logic [CNT_W-1:0] lo_raw;

    // Writes land only while the generator is stopped
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CNT_REGS; i++) begin
                cnt_q[i] <= '0;
            end
        end else if (cfg_wr && !enable) begin
            for (int i = 0; i < NUM_CNT_REGS; i++) begin
                if (cfg_addr == 2'(i)) begin
                    cnt_q[i] <= cfg_wdata;
                end
            end
        end
    end

    always_comb begin
        hi_raw = fast_sel ? cnt_q[SEL_FAST_HI] : cnt_q[SEL_STD_HI];
        lo_raw = fast_sel ? cnt_q[SEL_FAST_LO] : cnt_q[SEL_STD_LO];
    end

    // Raise short counts to the floor
    assign hi_eff = (hi_raw < CNT_W'(HI_MIN)) ? CNT_W'(HI_MIN) : hi_raw;
    assign lo_eff = (lo_raw < CNT_W'(LO_MIN)) ? CNT_W'(LO_MIN) : lo_raw;

endmodule

// File: rtl/sclgen_line_sampler.sv
module sclgen_line_sampler #(
    parameter int unsigned STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    output logic scl_seen
);

    logic [STAGES-1:0] smp_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) smp_q <= '1;
                else     smp_q[0] <= scl_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) smp_q <= '1;
                else     smp_q <= {smp_q[STAGES-2:0], scl_in};
            end
        end
    endgenerate

    assign scl_seen = smp_q[STAGES-1];

endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
    import sclgen_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       speed_mode,
    input  logic [CNT_W-1:0] hi_eff,
    input  logic [CNT_W-1:0] lo_eff,
    input  logic             scl_seen,
    output logic             fast_sel,
    output logic             scl_oe,
    output logic             hold_active,
    output logic             fall_tick,
    output logic             rise_tick
);

    localparam int unsigned TW       = CNT_W + 1;
    // The sampler latency is spent inside the high-phase overhead
    localparam int unsigned HIGH_ADD = HI_OVERHEAD - STAGES - 1;
    localparam int unsigned HOLD_ADD = HOLD_OVERHEAD - 1;
    localparam int unsigned LOW_ADD  = LO_OVERHEAD - 1;

    phase_e        st_q;
    logic [TW-1:0] cnt_q;
    logic          fast_q;
    logic          fall_q;
    logic          rise_q;

    logic [TW-1:0] hold_last;
    logic [TW-1:0] low_last;
    logic [TW-1:0] high_last;

    always_comb begin
        hold_last = TW'(hi_eff) + TW'(HOLD_ADD);
        low_last  = TW'(lo_eff) + TW'(LOW_ADD);
        high_last = TW'(hi_eff) + TW'(HIGH_ADD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            fast_q <= 1'b0;
            fall_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            fall_q <= 1'b0;
            rise_q <= 1'b0;
            if (!enable) begin
                st_q  <= PH_IDLE;
                cnt_q <= '0;
            end else begin
                case (st_q)
                    PH_IDLE: begin
                        st_q   <= PH_HOLD;
                        cnt_q  <= '0;
                        fast_q <= (speed_mode == SPEED_FAST);
                    end
                    PH_HOLD: begin
                        if (scl_seen) begin
                            if (cnt_q == hold_last) begin
                                st_q   <= PH_LOW;
                                cnt_q  <= '0;
                                fall_q <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    PH_LOW: begin
                        if (cnt_q == low_last) begin
                            st_q   <= PH_HIGH;
                            cnt_q  <= '0;
                            rise_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (scl_seen) begin
                            if (cnt_q == high_last) begin
                                st_q   <= PH_LOW;
                                cnt_q  <= '0;
                                fall_q <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: begin
                        st_q  <= PH_IDLE;
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    assign fast_sel    = fast_q;
    assign scl_oe      = (st_q == PH_LOW);
    assign hold_active = (st_q == PH_HOLD);
    assign fall_tick   = fall_q;
    assign rise_tick   = rise_q;

endmodule

// File: rtl/i2c_scl_period_gen.sv
module i2c_scl_period_gen #(
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned SAMPLE_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       speed_mode,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             hold_active,
    output logic             fall_tick,
    output logic             rise_tick
);

    logic             fast_sel;
    logic             scl_seen;
    logic [CNT_W-1:0] hi_eff;
    logic [CNT_W-1:0] lo_eff;

    sclgen_count_bank #(.CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .fast_sel  (fast_sel),
        .hi_eff    (hi_eff),
        .lo_eff    (lo_eff)
    );

    sclgen_line_sampler #(.STAGES(SAMPLE_STAGES)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .scl_seen (scl_seen)
    );

    sclgen_phase_fsm #(.CNT_W(CNT_W), .STAGES(SAMPLE_STAGES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .speed_mode  (speed_mode),
        .hi_eff      (hi_eff),
        .lo_eff      (lo_eff),
        .scl_seen    (scl_seen),
        .fast_sel    (fast_sel),
        .scl_oe      (scl_oe),
        .hold_active (hold_active),
        .fall_tick   (fall_tick),
        .rise_tick   (rise_tick)
    );

endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic scl_oe,
    input logic hold_active,
    input logic fall_tick,
    input logic rise_tick
);

    // Length of the current run of scl_oe = 1
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)         low_run <= '0;
        else if (scl_oe) low_run <= low_run + 1;
        else             low_run <= '0;
    end

    assert_fall_tick_R8: assert property (@(posedge clk) disable iff (rst)
        fall_tick == $rose(scl_oe));

    assert_rise_tick_R8: assert property (@(posedge clk) disable iff (rst)
        rise_tick |-> $fell(scl_oe));

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_oe && !hold_active));

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(scl_oe && hold_active));

    assert_hold_entry_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_active) |-> $past(enable));

    // A full low phase is never shorter than the clamped minimum plus one
    assert_low_floor_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_oe) && $past(enable)) |-> (low_run >= 32'd9));

endmodule

bind i2c_scl_period_gen sclgen_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .scl_oe      (scl_oe),
    .hold_active (hold_active),
    .fall_tick   (fall_tick),
    .rise_tick   (rise_tick)
);

// File: tb/tb_i2c_scl_period_gen.sv
module tb_i2c_scl_period_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  speed_mode = 2'd1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        scl_in;
    logic        scl_oe;
    logic        hold_active;
    logic        fall_tick;
    logic        rise_tick;

    int errors = 0;
    int checks = 0;
    int stretch_d = 0;
    int stretch_left = 0;

    always #2 clk = ~clk;

    // Line model: low while pulled, plus an optional slow rise
    always @(posedge clk) begin
        if (scl_oe === 1'b1)       stretch_left <= stretch_d;
        else if (stretch_left > 0) stretch_left <= stretch_left - 1;
    end
    assign scl_in = !((scl_oe === 1'b1) || (stretch_left != 0));

    i2c_scl_period_gen dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .speed_mode  (speed_mode),
        .cfg_wr      (cfg_wr),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .scl_in      (scl_in),
        .scl_oe      (scl_oe),
        .hold_active (hold_active),
        .fall_tick   (fall_tick),
        .rise_tick   (rise_tick)
    );

    typedef struct packed {
        logic [1:0]  spd;
        logic [15:0] sh;
        logic [15:0] sl;
        logic [15:0] fh;
        logic [15:0] fl;
        logic [15:0] exp_hold;
        logic [15:0] exp_low;
        logic [15:0] exp_high;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 16'd10, 16'd12, 16'd6,  16'd8,  16'd13, 16'd13, 16'd18},
        '{2'd2, 16'd10, 16'd12, 16'd6,  16'd8,  16'd9,  16'd9,  16'd14},
        '{2'd1, 16'd3,  16'd2,  16'd6,  16'd8,  16'd9,  16'd9,  16'd14},
        '{2'd2, 16'd3,  16'd2,  16'd20, 16'd30, 16'd23, 16'd31, 16'd28},
        '{2'd3, 16'd7,  16'd9,  16'd20, 16'd30, 16'd10, 16'd10, 16'd15}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Raise enable, then measure hold, first low and first high at negedges
    task automatic run_first(output int h, output int l, output int g,
                             output int ft, output int rt);
        h = 0; l = 0; g = 0; ft = 0; rt = 0;
        @(negedge clk);
        enable = 1'b1;
        while (!hold_active) @(negedge clk);
        while (hold_active) begin h++; @(negedge clk); end
        while (scl_oe) begin l++; if (fall_tick) ft++; @(negedge clk); end
        while (!scl_oe) begin g++; if (rise_tick) rt++; @(negedge clk); end
    endtask

    task automatic next_low(output int l);
        l = 0;
        while (scl_oe) @(negedge clk);
        while (!scl_oe) @(negedge clk);
        while (scl_oe) begin l++; @(negedge clk); end
    endtask

    task automatic stop_gen();
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, l, g, ft, rt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the pins
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 hold_active", int'(hold_active), 0);
        check("R1 ticks", int'(fall_tick) + int'(rise_tick), 0);

        // R1/R7: unwritten registers behave as the clamped minimums
        speed_mode = 2'd1;
        run_first(h, l, g, ft, rt);
        check("R1 reset hold", h, 9);
        check("R1 reset low", l, 9);
        check("R1 reset high", g, 14);
        stop_gen();

        // Table of modes and counts: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VEC[i].sh);
            wr(2'd1, VEC[i].sl);
            wr(2'd2, VEC[i].fh);
            wr(2'd3, VEC[i].fl);
            speed_mode = VEC[i].spd;
            run_first(h, l, g, ft, rt);
            check($sformatf("R6 hold vec%0d", i), h, int'(VEC[i].exp_hold));
            check($sformatf("R4 low vec%0d", i), l, int'(VEC[i].exp_low));
            check($sformatf("R5 high vec%0d", i), g, int'(VEC[i].exp_high));
            check($sformatf("R8 fall ticks vec%0d", i), ft, 1);
            check($sformatf("R8 rise ticks vec%0d", i), rt, 1);
            stop_gen();
        end

        // R3: write while enabled is dropped
        wr(2'd0, 16'd10);
        wr(2'd1, 16'd12);
        speed_mode = 2'd1;
        run_first(h, l, g, ft, rt);
        wr(2'd1, 16'd40);
        next_low(l);
        check("R3 low after blocked write", l, 13);
        stop_gen();
        run_first(h, l, g, ft, rt);
        check("R3 low after re-enable", l, 13);

        // R2: speed change while running waits for the next enable
        speed_mode = 2'd2;
        next_low(l);
        check("R2 low after live speed change", l, 13);
        stop_gen();
        run_first(h, l, g, ft, rt);
        check("R2 fast low after re-enable", l, 31);
        stop_gen();

        // R5: slow rise of 5 cycles lengthens the high phase
        speed_mode = 2'd1;
        stretch_d = 5;
        run_first(h, l, g, ft, rt);
        check("R5 stretched high", g, 23);
        stretch_d = 0;
        stop_gen();
        repeat (8) @(negedge clk);

        // R9: drop enable during a low phase
        @(negedge clk);
        enable = 1'b1;
        while (!scl_oe) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R9 released after low abort", int'(scl_oe), 0);
        check("R9 no hold after low abort", int'(hold_active), 0);
        repeat (3) @(negedge clk);

        // R9: drop enable during the start hold
        enable = 1'b1;
        while (!hold_active) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R9 hold cleared", int'(hold_active), 0);
        check("R9 line released in hold abort", int'(scl_oe), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule